// File: doc/BRIEF.md
# Paged Parallel I/O Controller with Edge Interrupts

This block gives a host 48 general-purpose lines, grouped as six 8-bit ports, behind a small byte-wide register window. Every line is an open-drain output. Writing a 1 to a port bit turns on the sink driver and pulls the pin low. Writing a 0 releases the pin, so an external pull-up can raise it. A read of a port returns the pin level inverted, so a released line can be used as an input.

The lowest 24 lines (ports 0 to 2) can also raise interrupts. Each of these lines has its own edge polarity and its own enable bit. Captured events are held in per-line pending flags. A page register selects which of three register banks appears in a three-byte paged area: polarity, enable or pending. A read-only summary byte shows which of the three ports holds an event. A single interrupt output is high while any pending flag is set.

Pin inputs pass through a two-stage synchroniser before they are read or edge-detected. Read data is registered.

Top module: `pio_edge_ctrl`

## Requirements
- R1: After reset, all sink outputs are 0, `irq` is 0, the page register reads 00h, and polarity, enable and pending are all zero.
- R2: A write to offset n (0 to 5) sets `pin_sink[8n+b]` to data bit b. A 1 sinks the line (pin low) and a 0 releases it.
- R3: A read of offset n (0 to 5) returns the inverted, synchronised level of the pins of port n, so a high pin reads 0.
- R4: Offset 7 holds the page in data bits 7:6. Page 0 is off, page 1 (40h) is polarity, page 2 (80h) is enable, and page 3 (C0h) is pending. The register reads back as {page, 000000}, and the lower written bits are dropped.
- R5: In page 1, offset 8+n (n = 0 to 2) reads and writes the polarity of port n. A 1 selects the rising edge and a 0 selects the falling edge.
- R6: In page 2, offset 8+n reads and writes the enable of port n. A line's pending flag is set only by an edge of its selected polarity while its enable bit is 1. Lines 24 to 47 never set a flag.
- R7: Writing 0 to an enable bit clears that line's pending flag. Writing the bit back to 1 does not restore the flag; only a later edge does.
- R8: In page 3, offset 8+n reads the pending flags of port n. Writes there are ignored.
- R9: Offset 6 reads {00000, |pend port2, |pend port1, |pend port0}. Writes to offset 6 are ignored.
- R10: `irq` is high in the cycle after any pending flag is set, and low in the cycle after none is set.
- R11: With page 0 selected, offsets 8 to 10 read 00h and writes there change nothing.
- R12: `bus_rdata` is loaded on a rising clock edge while `bus_rd` is 1 and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register offset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | 48 | Pin levels as seen on the board |
| pin_sink | output | 48 | 1 = sink driver on (pin pulled low) |
| irq | output | 1 | Any pending edge event |

## Verification
The hardest case to reach is the set of states where a pending flag should not exist. These are an edge of the wrong polarity, an edge on a disabled line, and a line that was re-enabled after it was cleared. From the ports, such a state looks the same as "nothing happened".

The bench models the open-drain pin as the external level ANDed with the inverted sink output. It then walks single lines through each of these cases in turn. After every step it reads back the pending bank, the summary byte and `irq`.

// File: rtl/pio_pkg.sv
package pio_pkg;
  typedef enum logic [1:0] {
    PG_NONE = 2'd0,
    PG_POL  = 2'd1,
    PG_EN   = 2'd2,
    PG_ID   = 2'd3
  } page_e;

  localparam int OFS_SUMMARY = 6;
  localparam int OFS_PAGE    = 7;
  localparam int OFS_BANK    = 8;
endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
  parameter int W      = 48,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pio_edge_port.sv
module pio_edge_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl,
  input  logic         pol_we,
  input  logic         en_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] pol_q,
  output logic [W-1:0] en_q,
  output logic [W-1:0] pend_q
);
  logic [W-1:0] prev, rise, fall, hit, en_nx;

  always_comb begin
    rise  = lvl & ~prev;
    fall  = ~lvl & prev;
    hit   = en_q & ((pol_q & rise) | (~pol_q & fall));
    en_nx = en_we ? wdata : en_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev   <= '0;
      pol_q  <= '0;
      en_q   <= '0;
      pend_q <= '0;
    end else begin
      prev   <= lvl;
      if (pol_we) pol_q <= wdata;
      en_q   <= en_nx;
      pend_q <= (pend_q | hit) & en_nx;
    end
  end
endmodule

// File: rtl/pio_edge_ctrl.sv
module pio_edge_ctrl
  import pio_pkg::*;
#(
  parameter int NUM_PORTS   = 6,
  parameter int PORT_W      = 8,
  parameter int IRQ_PORTS   = 3,
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic                        bus_rd,
  input  logic                        bus_wr,
  input  logic [PORT_W-1:0]           bus_wdata,
  output logic [PORT_W-1:0]           bus_rdata,
  input  logic [NUM_PORTS*PORT_W-1:0] pin_in,
  output logic [NUM_PORTS*PORT_W-1:0] pin_sink,
  output logic                        irq
);
  localparam int LINES     = NUM_PORTS * PORT_W;
  localparam int IRQ_LINES = IRQ_PORTS * PORT_W;

  logic [NUM_PORTS-1:0][PORT_W-1:0] out_q, lvl_p;
  logic [IRQ_PORTS-1:0][PORT_W-1:0] pol_p, en_p, pend_p;
  logic [IRQ_PORTS-1:0]             bank_hit, pol_we, en_we;
  logic [LINES-1:0]                 lvl_flat;
  logic [IRQ_LINES-1:0]             en_all, pend_all;
  page_e                            page_q;
  logic [PORT_W-1:0]                rd_mux;

  pio_sync #(.W(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(lvl_flat)
  );
  assign lvl_p = lvl_flat;

  always_comb begin
    for (int n = 0; n < IRQ_PORTS; n++) begin
      bank_hit[n] = (bus_addr == ADDR_W'(OFS_BANK + n));
      pol_we[n]   = bus_wr && bank_hit[n] && (page_q == PG_POL);
      en_we[n]    = bus_wr && bank_hit[n] && (page_q == PG_EN);
    end
  end

  for (genvar g = 0; g < IRQ_PORTS; g++) begin : g_edge
    pio_edge_port #(.W(PORT_W)) u_edge (
      .clk(clk), .rst(rst), .lvl(lvl_p[g]),
      .pol_we(pol_we[g]), .en_we(en_we[g]), .wdata(bus_wdata),
      .pol_q(pol_p[g]), .en_q(en_p[g]), .pend_q(pend_p[g])
    );
  end

  assign en_all   = en_p;
  assign pend_all = pend_p;
  assign pin_sink = out_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q  <= '0;
      page_q <= PG_NONE;
    end else if (bus_wr) begin
      for (int p = 0; p < NUM_PORTS; p++)
        if (bus_addr == ADDR_W'(p)) out_q[p] <= bus_wdata;
      if (bus_addr == ADDR_W'(OFS_PAGE))
        page_q <= page_e'(bus_wdata[PORT_W-1 -: 2]);
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int p = 0; p < NUM_PORTS; p++)
      if (bus_addr == ADDR_W'(p)) rd_mux = ~lvl_p[p];
    if (bus_addr == ADDR_W'(OFS_SUMMARY))
      for (int n = 0; n < IRQ_PORTS; n++) rd_mux[n] = |pend_p[n];
    if (bus_addr == ADDR_W'(OFS_PAGE))
      rd_mux = {page_q, {(PORT_W-2){1'b0}}};
    for (int n = 0; n < IRQ_PORTS; n++) begin
      if (bank_hit[n]) begin
        case (page_q)
          PG_POL:  rd_mux = pol_p[n];
          PG_EN:   rd_mux = en_p[n];
          PG_ID:   rd_mux = pend_p[n];
          default: rd_mux = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      if (bus_rd) bus_rdata <= rd_mux;
      irq <= |pend_all;
    end
  end
endmodule

// File: rtl/pio_edge_ctrl_chk.sv
module pio_edge_ctrl_chk #(
  parameter int LINES     = 48,
  parameter int IRQ_LINES = 24,
  parameter int DW        = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 bus_rd,
  input logic                 bus_wr,
  input logic [DW-1:0]        bus_rdata,
  input logic [LINES-1:0]     pin_sink,
  input logic                 irq,
  input logic [IRQ_LINES-1:0] en_all,
  input logic [IRQ_LINES-1:0] pend_all
);
  // R6 / R7: no pending flag on a disabled line
  p_pend_only_enabled_r7: assert property (@(posedge clk) disable iff (rst)
    (pend_all & ~en_all) == '0);

  // R6: a flag only appears on a line that was enabled in the previous cycle
  p_new_pend_needs_en_r6: assert property (@(posedge clk) disable iff (rst)
    (pend_all & ~$past(pend_all) & ~$past(en_all)) == '0);

  // R10: irq follows pending one cycle later
  p_irq_set_r10: assert property (@(posedge clk) disable iff (rst)
    (|pend_all) |=> irq);
  p_irq_clr_r10: assert property (@(posedge clk) disable iff (rst)
    !(|pend_all) |=> !irq);

  // R2: sink outputs change only on a write
  p_sink_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !bus_wr |=> $stable(pin_sink));

  // R12: read data holds without a read strobe
  p_rdata_hold_r12: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));
endmodule

bind pio_edge_ctrl pio_edge_ctrl_chk #(
  .LINES(NUM_PORTS * PORT_W), .IRQ_LINES(IRQ_PORTS * PORT_W), .DW(PORT_W)
) u_chk (
  .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .bus_rdata(bus_rdata), .pin_sink(pin_sink), .irq(irq),
  .en_all(en_all), .pend_all(pend_all)
);

// File: tb/pio_edge_ctrl_tb.sv
module pio_edge_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic [3:0]  bus_addr;
  logic        bus_rd, bus_wr;
  logic [7:0]  bus_wdata, bus_rdata;
  logic [47:0] pin_in, pin_sink, ext_lvl;
  logic        irq;
  int          n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  // open-drain model: the pin is high only if the outside world leaves it high and the sink is off
  assign pin_in = ext_lvl & ~pin_sink;

  pio_edge_ctrl u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_sink(pin_sink), .irq(irq)
  );

  task automatic chk(input string tag, input logic [47:0] act, input logic [47:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 sink after reset", pin_sink, 48'h0);
    chk("R1 irq after reset", {47'h0, irq}, 48'h0);
    rd(4'd7, d); chk("R1 page reads 00h", {40'h0, d}, 48'h0);
    rd(4'd6, d); chk("R1 summary zero", {40'h0, d}, 48'h0);
    rd(4'd0, d); chk("R3 released high pins read 0", {40'h0, d}, 48'h0);
    wr(4'd7, 8'h80);
    rd(4'd8, d); chk("R1 enable zero", {40'h0, d}, 48'h0);
    wr(4'd7, 8'h00);
  endtask

  task automatic t_output();
    logic [7:0] d;
    wr(4'd0, 8'hA5);
    chk("R2 port0 sink", {40'h0, pin_sink[7:0]}, 48'hA5);
    wr(4'd5, 8'h3C);
    chk("R2 port5 sink", {40'h0, pin_sink[47:40]}, 48'h3C);
    chk("R2 other ports untouched", {16'h0, pin_sink[39:8]}, 48'h0);
    settle();
    rd(4'd0, d); chk("R3 sunk pins read 1", {40'h0, d}, 48'hA5);
    ext_lvl[31:24] = 8'h0F;
    settle();
    rd(4'd3, d); chk("R3 external low reads 1", {40'h0, d}, 48'hF0);
    ext_lvl[31:24] = 8'hFF;
    wr(4'd0, 8'h00);
    wr(4'd5, 8'h00);
    settle();
  endtask

  task automatic t_page();
    logic [7:0] d;
    wr(4'd7, 8'hFF);
    rd(4'd7, d); chk("R4 page readback drops low bits", {40'h0, d}, 48'hC0);
    wr(4'd7, 8'h40);
    wr(4'd8, 8'h11); wr(4'd9, 8'h22); wr(4'd10, 8'h33);
    rd(4'd8, d);  chk("R5 polarity port0", {40'h0, d}, 48'h11);
    rd(4'd9, d);  chk("R5 polarity port1", {40'h0, d}, 48'h22);
    rd(4'd10, d); chk("R5 polarity port2", {40'h0, d}, 48'h33);
  endtask

  task automatic t_page_off();
    logic [7:0] d;
    wr(4'd7, 8'h00);
    wr(4'd8, 8'hFF);
    rd(4'd8, d); chk("R11 page0 reads 0", {40'h0, d}, 48'h0);
    wr(4'd7, 8'h40);
    rd(4'd8, d); chk("R11 polarity kept", {40'h0, d}, 48'h11);
    wr(4'd7, 8'h80);
    rd(4'd8, d); chk("R11 enable kept", {40'h0, d}, 48'h0);
  endtask

  task automatic t_edges();
    logic [7:0] d;
    // port0 polarity 11h: bit0 rising, bit1 falling; enable bits 0 and 1
    wr(4'd7, 8'h80); wr(4'd8, 8'h03);
    ext_lvl[0] = 1'b0; settle();
    rd(4'd6, d); chk("R6 wrong-polarity edge ignored", {40'h0, d}, 48'h0);
    chk("R10 irq low with no event", {47'h0, irq}, 48'h0);
    ext_lvl[0] = 1'b1; settle();
    chk("R10 irq high on event", {47'h0, irq}, 48'h1);
    rd(4'd6, d); chk("R9 summary port0", {40'h0, d}, 48'h01);
    ext_lvl[1] = 1'b0; settle();
    wr(4'd7, 8'hC0);
    rd(4'd8, d); chk("R8 pending port0", {40'h0, d}, 48'h03);
    ext_lvl[2] = 1'b0; settle(); ext_lvl[2] = 1'b1; settle();
    rd(4'd8, d); chk("R6 disabled line no flag", {40'h0, d}, 48'h03);
    wr(4'd8, 8'h00);
    rd(4'd8, d); chk("R8 pending write ignored", {40'h0, d}, 48'h03);
    wr(4'd6, 8'hFF);
    rd(4'd6, d); chk("R9 summary write ignored", {40'h0, d}, 48'h01);
    ext_lvl[24] = 1'b0; settle(); ext_lvl[24] = 1'b1; settle();
    rd(4'd6, d); chk("R6 upper lines never interrupt", {40'h0, d}, 48'h01);
  endtask

  task automatic t_clear();
    logic [7:0] d;
    wr(4'd7, 8'h80); wr(4'd8, 8'h02);
    wr(4'd7, 8'hC0);
    rd(4'd8, d); chk("R7 disable clears flag", {40'h0, d}, 48'h02);
    chk("R10 irq still high", {47'h0, irq}, 48'h1);
    wr(4'd7, 8'h80); wr(4'd8, 8'h00);
    @(negedge clk);
    chk("R10 irq low after clear", {47'h0, irq}, 48'h0);
    wr(4'd8, 8'h03);
    wr(4'd7, 8'hC0);
    rd(4'd8, d); chk("R7 re-enable does not restore", {40'h0, d}, 48'h0);
    ext_lvl[0] = 1'b0; settle();
    ext_lvl[0] = 1'b1; settle();
    rd(4'd8, d); chk("R7 re-armed line catches edge", {40'h0, d}, 48'h01);
    // port2 bit7 (line 23) rising: polarity 33h has bit7 = 0 -> set 80h
    wr(4'd7, 8'h40); wr(4'd10, 8'h80);
    wr(4'd7, 8'h80); wr(4'd10, 8'h80);
    ext_lvl[23] = 1'b0; settle(); ext_lvl[23] = 1'b1; settle();
    rd(4'd6, d); chk("R9 summary ports 0 and 2", {40'h0, d}, 48'h05);
  endtask

  task automatic t_hold();
    logic [7:0] d, d2;
    rd(4'd7, d);
    @(negedge clk); bus_addr = 4'd6;
    repeat (3) @(negedge clk);
    d2 = bus_rdata;
    chk("R12 rdata holds without strobe", {40'h0, d2}, {40'h0, d});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; bus_addr = '0; bus_rd = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    ext_lvl = '1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    settle();
    t_reset();
    t_output();
    t_page();
    t_page_off();
    t_edges();
    t_clear();
    t_hold();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule